// File: doc/BRIEF.md
# Look-Up-Table Logic Cell

This block is one configurable logic cell for a programmable fabric. A sixteen-entry, one-bit-wide truth table, indexed by four data inputs, produces any function of those inputs. The result can be gated by a cascade input from a neighbouring cell to build wide AND functions. It can also be split into two halves that act as a one-bit adder stage on a dedicated carry chain. A single storage element follows the table. It can be set up as a D, T, JK or SR flip-flop, or skipped, so that the main output is either combinational or registered.

All configuration lives in one serial chain of 22 bits. It is shifted in one bit per clock while the load enable is high. In packing mode the flip-flop takes its data from its own input pin, so the table and the flip-flop can serve two unrelated functions at once. The flip-flop has a clock enable and active-low asynchronous clear and preset controls, and the clear wins over the preset. The global reset is synchronous and active low. It empties the configuration chain and clears the flip-flop.

Top module: `lut_logic_cell`

## Requirements
- R1: While `rst_n` is low at a clock edge, the whole configuration chain and the flip-flop become 0. After reset `comb_out`, `reg_out`, `cell_out`, `carry_out` and `casc_out` are all 0.
- R2: At each clock edge with `cfg_en` high, `cfg_bit` enters at chain bit 21 and every chain bit moves one place toward bit 0. After 22 loads, the first bit sent sits in bit 0. With `cfg_en` low the chain holds its contents. Bits 15:0 are table entries 0..15. Bits 17:16 select the flip-flop kind (00 D, 01 T, 10 JK, 11 SR). Bit 18 selects arithmetic mode, bit 19 enables the cascade gate, bit 20 enables packing and bit 21 enables bypass.
- R3: In logic mode, the table result is entry number `data_in`, where `data_in[3]` is the index MSB.
- R4: In arithmetic mode, the table result is entry {0,`carry_in`,`data_in[1]`,`data_in[0]`} and `carry_out` is entry {1,`carry_in`,`data_in[1]`,`data_in[0]`}. `data_in[3:2]` are ignored. Outside arithmetic mode `carry_out` is 0.
- R5: `comb_out` is the table result ANDed with `casc_in` when the cascade bit is set, and the plain table result otherwise. `casc_out` always equals `comb_out`.
- R6: `cell_out` equals `comb_out` when the bypass bit is set and `reg_out` otherwise.
- R7: With packing set, the flip-flop's primary data is `reg_din` and `comb_out` is unaffected. With packing clear, the primary data is `comb_out`.
- R8: D kind loads the primary data. T kind toggles when the primary data is 1 and holds otherwise.
- R9: JK kind takes J from the primary data and K from `reg_aux`: 00 holds, 10 sets, 01 clears, 11 toggles. SR kind takes S from the primary data and R from `reg_aux`: 10 sets, 01 clears, 00 and 11 hold.
- R10: With `reg_ce` low the flip-flop holds its value at a clock edge.
- R11: `clr_n` low forces the flip-flop to 0 at once and `pre_n` low forces it to 1 at once, with no clock needed. The clear has priority over the preset, and both have priority over reset and clocked updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| data_in | input | 4 | Table index inputs |
| reg_din | input | 1 | Flip-flop data in packing mode |
| reg_aux | input | 1 | K or R input of the flip-flop |
| reg_ce | input | 1 | Flip-flop clock enable |
| clr_n | input | 1 | Asynchronous active-low clear |
| pre_n | input | 1 | Asynchronous active-low preset |
| carry_in | input | 1 | Carry from the previous cell |
| carry_out | output | 1 | Carry to the next cell |
| casc_in | input | 1 | Cascade from the previous cell |
| casc_out | output | 1 | Cascade to the next cell |
| comb_out | output | 1 | Combinational result |
| reg_out | output | 1 | Flip-flop output |
| cell_out | output | 1 | Selected main output |

## Verification
A wrong bit in the configuration chain shows at the ports on the first cycle in which the affected table entry or mode is used. A misplaced table bit gives the wrong `comb_out` for one index value. A wrong mode bit changes `carry_out`, `cell_out` or the flip-flop's next-state rule at once. A wrong flip-flop value shows on `reg_out` right after the clock edge or asynchronous control that caused it, and a wrong toggle keeps the error visible until the next load or clear. For these reasons every output is compared against a behavioural model after every clock edge, and a fault is reported in the cycle where it first appears. Directed checks for each table pattern, flip-flop kind and control priority are added on top of that comparison.

// File: rtl/lut_cell_pkg.sv
// Package: shared types for the look-up-table logic cell.
// Assumes the mode word sits directly above the table bits in the serial chain.
package lut_cell_pkg;

    // Flip-flop behaviour selected by configuration (chain bits 17:16).
    typedef enum logic [1:0] {
        KIND_D  = 2'b00,
        KIND_T  = 2'b01,
        KIND_JK = 2'b10,
        KIND_SR = 2'b11
    } reg_kind_e;

    // Mode word: packed MSB first, so bypass is the top chain bit.
    typedef struct packed {
        logic      bypass;
        logic      pack;
        logic      casc_en;
        logic      arith;
        reg_kind_e kind;
    } cell_mode_t;

    localparam int MODE_BITS = $bits(cell_mode_t);

endpackage

// File: rtl/lut_cfg_chain.sv
// Serial configuration chain: one bit enters at the top per enabled clock.
// The first bit sent ends in bit 0. Assumes the synchronous active-low reset.
module lut_cfg_chain #(
    parameter int CFG_BITS = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                cfg_bit,
    output logic [CFG_BITS-1:0] cfg_q
);

    // Shift the chain toward bit 0 while loading, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (cfg_en)
            cfg_q <= {cfg_bit, cfg_q[CFG_BITS-1:1]};
    end

    assert_cfg_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_q[CFG_BITS-1] == $past(cfg_bit)));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_q));

endmodule

// File: rtl/lut_eval.sv
// Table evaluation: logic mode reads the whole table. Arithmetic mode reads the
// lower half as sum and the upper half as carry. An optional cascade AND follows.
// Assumes LUT_INPUTS >= 3.
module lut_eval #(
    parameter int LUT_INPUTS = 4
) (
    input  logic [(1<<LUT_INPUTS)-1:0] table_bits,
    input  logic [LUT_INPUTS-1:0]      data_in,
    input  logic                       arith,
    input  logic                       casc_en,
    input  logic                       carry_in,
    input  logic                       casc_in,
    output logic                       comb_out,
    output logic                       carry_out
);

    localparam int HALF_W = LUT_INPUTS - 1;

    logic [HALF_W-1:0] half_idx;
    logic              lut_res;

    // Build the half-table index from carry and the low data inputs.
    always_comb half_idx = {carry_in, data_in[HALF_W-2:0]};

    // Choose the table result and carry for the configured mode.
    always_comb begin
        if (arith) begin
            lut_res   = table_bits[{1'b0, half_idx}];
            carry_out = table_bits[{1'b1, half_idx}];
        end else begin
            lut_res   = table_bits[data_in];
            carry_out = 1'b0;
        end
    end

    // Gate with the neighbour's cascade signal when enabled.
    always_comb comb_out = lut_res & (casc_in | ~casc_en);

endmodule

// File: rtl/lut_cell_reg.sv
// Configurable flip-flop: D, T, JK or SR rule, clock enable, asynchronous
// active-low clear (highest priority) and preset, then synchronous reset.
module lut_cell_reg
    import lut_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_n,
    input  logic      pre_n,
    input  logic      ce,
    input  reg_kind_e kind,
    input  logic      d_a,
    input  logic      d_b,
    output logic      q
);

    logic q_next;

    // Next-state rule for the configured flip-flop kind.
    always_comb begin
        unique case (kind)
            KIND_D:  q_next = d_a;
            KIND_T:  q_next = q ^ d_a;
            KIND_JK: q_next = (d_a & ~q) | (~d_b & q);
            KIND_SR: q_next = (d_a & ~d_b) ? 1'b1 : ((d_b & ~d_a) ? 1'b0 : q);
            default: q_next = q;
        endcase
    end

    // State update: asynchronous clear, then preset, then reset and enable.
    always_ff @(posedge clk or negedge clr_n or negedge pre_n) begin
        if (!clr_n)
            q <= 1'b0;
        else if (!pre_n)
            q <= 1'b1;
        else if (!rst_n)
            q <= 1'b0;
        else if (ce)
            q <= q_next;
    end

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> !q);

    assert_preset_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !pre_n) |-> q);

    assert_ce_hold_R10: assert property (@(posedge clk)
        disable iff (!rst_n || !clr_n || !pre_n)
        !ce |=> $stable(q));

    assert_t_toggle_R8: assert property (@(posedge clk)
        disable iff (!rst_n || !clr_n || !pre_n)
        (ce && kind == KIND_T && d_a) |=> (q != $past(q)));

endmodule

// File: rtl/lut_logic_cell.sv
// Top of the logic cell: configuration chain, table evaluation and the
// configurable flip-flop, plus the bypass selection of the main output.
// Assumes configuration is stable while the cell is in functional use.
module lut_logic_cell
    import lut_cell_pkg::*;
#(
    parameter int LUT_INPUTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_en,
    input  logic                  cfg_bit,
    input  logic [LUT_INPUTS-1:0] data_in,
    input  logic                  reg_din,
    input  logic                  reg_aux,
    input  logic                  reg_ce,
    input  logic                  clr_n,
    input  logic                  pre_n,
    input  logic                  carry_in,
    output logic                  carry_out,
    input  logic                  casc_in,
    output logic                  casc_out,
    output logic                  comb_out,
    output logic                  reg_out,
    output logic                  cell_out
);

    localparam int TABLE_DEPTH = 1 << LUT_INPUTS;
    localparam int CFG_BITS    = TABLE_DEPTH + MODE_BITS;

    logic [CFG_BITS-1:0]    cfg_q;
    logic [TABLE_DEPTH-1:0] table_bits;
    cell_mode_t             mode;
    logic                   reg_data;

    lut_cfg_chain #(.CFG_BITS(CFG_BITS)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_bit (cfg_bit),
        .cfg_q   (cfg_q)
    );

    // Split the chain into the table and the mode word.
    always_comb begin
        table_bits = cfg_q[TABLE_DEPTH-1:0];
        mode       = cell_mode_t'(cfg_q[CFG_BITS-1:TABLE_DEPTH]);
    end

    lut_eval #(.LUT_INPUTS(LUT_INPUTS)) eval_i (
        .table_bits (table_bits),
        .data_in    (data_in),
        .arith      (mode.arith),
        .casc_en    (mode.casc_en),
        .carry_in   (carry_in),
        .casc_in    (casc_in),
        .comb_out   (comb_out),
        .carry_out  (carry_out)
    );

    // Primary flip-flop data: packing input or table result.
    always_comb reg_data = mode.pack ? reg_din : comb_out;

    lut_cell_reg reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .pre_n (pre_n),
        .ce    (reg_ce),
        .kind  (mode.kind),
        .d_a   (reg_data),
        .d_b   (reg_aux),
        .q     (reg_out)
    );

    // Drive the cascade output and select the main output.
    always_comb begin
        casc_out = comb_out;
        cell_out = mode.bypass ? comb_out : reg_out;
    end

    assert_cascade_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.casc_en && !casc_in) |-> !comb_out);

    assert_carry_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.arith |-> !carry_out);

endmodule

// File: tb/lut_logic_cell_tb.sv
// Bench: behavioural model updated on every edge, compared after every edge,
// plus directed checks with values worked out by hand.
module lut_logic_cell_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0, cfg_bit = 1'b0;
    logic [3:0] data_in = '0;
    logic       reg_din = 1'b0, reg_aux = 1'b0, reg_ce = 1'b1;
    logic       clr_n = 1'b1, pre_n = 1'b1;
    logic       carry_in = 1'b0, casc_in = 1'b0;
    logic       carry_out, casc_out, comb_out, reg_out, cell_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [21:0] mcfg = '0;
    logic        mq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lut_logic_cell dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .data_in(data_in), .reg_din(reg_din), .reg_aux(reg_aux),
        .reg_ce(reg_ce), .clr_n(clr_n), .pre_n(pre_n),
        .carry_in(carry_in), .carry_out(carry_out),
        .casc_in(casc_in), .casc_out(casc_out),
        .comb_out(comb_out), .reg_out(reg_out), .cell_out(cell_out)
    );

    function automatic logic [21:0] mk(input logic [15:0] tbl, input logic [1:0] kind,
                                       input logic ar, input logic ce_, input logic pk,
                                       input logic by);
        return {by, pk, ce_, ar, kind, tbl};
    endfunction

    function automatic logic m_carry();
        int idx = 8 + (int'(carry_in) * 4) + int'(data_in[1:0]);
        if (!mcfg[18]) return 1'b0;
        return mcfg[idx];
    endfunction

    function automatic logic m_comb();
        logic r;
        if (mcfg[18]) r = mcfg[int'(carry_in) * 4 + int'(data_in[1:0])];
        else          r = mcfg[int'(data_in)];
        if (mcfg[19]) r = r && casc_in;
        return r;
    endfunction

    // Model of the configuration chain.
    always @(posedge clk) begin
        if (!rst_n) mcfg <= '0;
        else if (cfg_en) mcfg <= {cfg_bit, mcfg[21:1]};
    end

    // Model of the flip-flop.
    always @(posedge clk or negedge clr_n or negedge pre_n) begin
        logic a;
        a = mcfg[20] ? reg_din : m_comb();
        if (!clr_n) mq <= 1'b0;
        else if (!pre_n) mq <= 1'b1;
        else if (!rst_n) mq <= 1'b0;
        else if (reg_ce) begin
            case (mcfg[17:16])
                2'b00: mq <= a;
                2'b01: mq <= a ? !mq : mq;
                2'b10: mq <= (a && reg_aux) ? !mq : (a ? 1'b1 : (reg_aux ? 1'b0 : mq));
                default: mq <= (a && !reg_aux) ? 1'b1 : ((!a && reg_aux) ? 1'b0 : mq);
            endcase
        end
    end

    task automatic chk(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        logic ec;
        ec = m_comb();
        chk({tag, " comb_out"}, comb_out, ec);
        chk({tag, " casc_out R5"}, casc_out, ec);
        chk({tag, " carry_out R4"}, carry_out, m_carry());
        chk({tag, " reg_out"}, reg_out, mq);
        chk({tag, " cell_out R6"}, cell_out, mcfg[21] ? ec : mq);
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare_all(tag);
    endtask

    task automatic load(input logic [21:0] w);
        for (int i = 0; i < 22; i++) begin
            cfg_en = 1'b1;
            cfg_bit = w[i];
            tick("R2 load");
        end
        cfg_en = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        tick("R1 reset");
        chk("R1 comb_out", comb_out, 1'b0);
        chk("R1 reg_out", reg_out, 1'b0);
        chk("R1 cell_out", cell_out, 1'b0);
        chk("R1 carry_out", carry_out, 1'b0);
        rst_n = 1'b1;

        // R3: four-input AND, then XOR parity
        load(mk(16'h8000, 2'b00, 0, 0, 0, 1));
        for (int i = 0; i < 16; i++) begin
            data_in = 4'(i);
            tick("R3 and");
            chk("R3 and value", comb_out, (i == 15));
        end
        // R2: hold with cfg_en low while cfg_bit wiggles
        data_in = 4'hF;
        for (int i = 0; i < 4; i++) begin
            cfg_bit = i[0];
            tick("R2 hold");
        end
        chk("R2 hold value", comb_out, 1'b1);
        load(mk(16'h6996, 2'b00, 0, 0, 0, 1));
        for (int i = 0; i < 16; i++) begin
            data_in = 4'(i);
            tick("R3 xor");
            chk("R3 xor value", comb_out, ^data_in);
        end

        // R4: adder stage, upper inputs scrambled
        load(mk(16'hE896, 2'b00, 1, 0, 0, 1));
        for (int i = 0; i < 8; i++) begin
            carry_in = i[2];
            data_in = {i[0] ^ i[1], ~i[2], i[1], i[0]};
            tick("R4 arith");
            chk("R4 sum", comb_out, i[0] ^ i[1] ^ i[2]);
            chk("R4 carry", carry_out, (i[0] & i[1]) | (i[0] & i[2]) | (i[1] & i[2]));
        end
        carry_in = 1'b0;

        // R5: cascade gate on an all-ones table
        load(mk(16'hFFFF, 2'b00, 0, 1, 0, 1));
        casc_in = 1'b0; tick("R5 casc0");
        chk("R5 killed", comb_out, 1'b0);
        casc_in = 1'b1; tick("R5 casc1");
        chk("R5 passed", casc_out, 1'b1);

        // R6/R8: registered D output, bypass off
        load(mk(16'h8000, 2'b00, 0, 0, 0, 0));
        data_in = 4'hF; tick("R8 d1");
        chk("R8 D load 1", reg_out, 1'b1);
        chk("R6 registered", cell_out, 1'b1);
        data_in = 4'h0; #1;
        chk("R6 not bypassed", cell_out, 1'b1);
        tick("R8 d0");
        chk("R8 D load 0", reg_out, 1'b0);

        // R10: clock enable low holds
        data_in = 4'hF; reg_ce = 1'b0;
        tick("R10 hold"); tick("R10 hold");
        chk("R10 held", reg_out, 1'b0);
        reg_ce = 1'b1;

        // R8: T kind toggles on an all-ones table
        load(mk(16'hFFFF, 2'b01, 0, 0, 0, 0));
        begin
            logic prev;
            prev = reg_out;
            tick("R8 t");
            chk("R8 T toggle", reg_out, !prev);
            tick("R8 t");
            chk("R8 T toggle back", reg_out, prev);
        end

        // R7/R9: JK with packing, table is XOR for the unrelated function
        load(mk(16'h6996, 2'b10, 0, 0, 1, 0));
        clr_n = 1'b0; #1; clr_n = 1'b1;
        data_in = 4'h1;
        reg_din = 1; reg_aux = 0; tick("R9 jk set");  chk("R9 JK set", reg_out, 1'b1);
        chk("R7 table independent", comb_out, 1'b1);
        reg_din = 0; reg_aux = 0; tick("R9 jk hold"); chk("R9 JK hold", reg_out, 1'b1);
        reg_din = 1; reg_aux = 1; tick("R9 jk tog");  chk("R9 JK toggle", reg_out, 1'b0);
        data_in = 4'h3;
        reg_din = 1; reg_aux = 1; tick("R9 jk tog");  chk("R9 JK toggle 2", reg_out, 1'b1);
        chk("R7 table independent 2", comb_out, 1'b0);
        reg_din = 0; reg_aux = 1; tick("R9 jk clr");  chk("R9 JK clear", reg_out, 1'b0);

        // R9: SR kind with packing
        load(mk(16'h0000, 2'b11, 0, 0, 1, 0));
        reg_din = 1; reg_aux = 0; tick("R9 sr set");  chk("R9 SR set", reg_out, 1'b1);
        reg_din = 1; reg_aux = 1; tick("R9 sr both"); chk("R9 SR both hold", reg_out, 1'b1);
        reg_din = 0; reg_aux = 1; tick("R9 sr rst");  chk("R9 SR reset", reg_out, 1'b0);
        reg_din = 0; reg_aux = 0; tick("R9 sr hold"); chk("R9 SR hold", reg_out, 1'b0);

        // R11: asynchronous preset and clear, clear wins
        pre_n = 1'b0; #1;
        chk("R11 preset", reg_out, 1'b1);
        clr_n = 1'b0; #1;
        chk("R11 clear priority", reg_out, 1'b0);
        tick("R11 held low");
        chk("R11 clear over clock", reg_out, 1'b0);
        clr_n = 1'b1; pre_n = 1'b1;
        tick("R11 released");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule